// File: doc/BRIEF.md
# Serial Sample Transmitter (Word-Select Slave)

This block sends two stored 24-bit audio samples, a left one and a right one, over a single serial data line. An external master supplies the bit clock and the word-select signal. The block works as the slave transmitter. It brings both external signals into its own system clock domain through synchronizer chains, and it detects the edges itself. Each time word select changes, the block latches the sample for the newly chosen channel. It then shifts that sample out most significant bit first, one bit on each falling edge of the bit clock.

Words may be longer or shorter than the sample. If a word is shorter, the remaining low bits are simply not sent. If it is longer, every bit past the 24th is sent as zero. The block also divides the system clock into a data-rate clock and a word-rate clock. It drives one registered output-enable that the pad ring uses to put the data line and both divided clocks into high impedance. Every output is a register updated on the rising system clock edge.

Top module: `serial_sample_tx`

## Requirements
- R1: While word select is high at a word change, the right sample is sent. While it is low, the left sample is sent.
- R2: `sd_o` changes only on the third rising system clock edge after the bit clock is first sampled low following a high level. It is stable otherwise, so the old value is still present two edges after the fall. The bit clock and word select must each hold a level for at least two system clocks.
- R3: After any change of word select, the first falling bit-clock edge that follows drives the MSB (bit 23) of the newly latched sample. If the word-select change and the falling edge are detected in the same cycle, that edge already drives the new MSB.
- R4: Bit k of a word (counting from 0 at the MSB) is sample bit 23-k for k below 24, and 0 for k of 24 or more. A short word is truncated, and the next word-select change restarts at the MSB.
- R5: `out_oe` equals the value of `out_en` at the previous rising clock edge. A high level means the pads of `sd_o`, `dclk_o` and `wclk_o` are driven; a low level means they are high impedance.
- R6: The sample is captured when word select changes. Changing `left_sample` or `right_sample` later in the word has no effect on the bits of that word.
- R7: After reset, with m rising edges counted since reset was released, `dclk_o` equals bit 1 of m and `wclk_o` equals bit 7 of m. These are the system clock divided by 4 and by 256. `wclk_o` only changes together with a falling `dclk_o`.
- R8: In reset, `sd_o`, `out_oe`, `dclk_o` and `wclk_o` are 0. Falling bit-clock edges before the first word-select change send 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| left_sample | input | 24 | Left-channel sample from the decoder |
| right_sample | input | 24 | Right-channel sample from the decoder |
| bclk_in | input | 1 | External bit clock (asynchronous) |
| ws_in | input | 1 | External word select, high selects right (asynchronous) |
| out_en | input | 1 | Output-drive request for the pads |
| sd_o | output | 1 | Serial data, MSB first |
| dclk_o | output | 1 | System clock divided by 4 |
| wclk_o | output | 1 | System clock divided by 256 |
| out_oe | output | 1 | Registered pad enable for sd_o, dclk_o, wclk_o |

## Verification
A wrong bit counter or a wrong shift register shows up at `sd_o` within one bit time. The faults it produces are a rotated or truncated word, a padding bit that is not zero, or a missing MSB after word select toggles. The bench therefore compares every bit of words of 16, 24, 25, 28, 31 and 32 bits, against samples computed in the bench. A wrong synchronizer depth or a wrong edge detector moves the data change away from the third system edge after the fall, and the bench checks that edge exactly. A wrong divider shows up within 256 cycles, because the first 512 cycles after reset are compared one by one.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  function automatic chan_e chan_of(input logic ws_level);
    return ws_level ? CH_RIGHT : CH_LEFT;
  endfunction
endpackage

// File: rtl/sstx_sync.sv
module sstx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= '0;
          else     chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sstx_edges.sv
module sstx_edges (
  input  logic clk,
  input  logic rst,
  input  logic bclk_s,
  input  logic ws_s,
  output logic bclk_fall,
  output logic ws_change,
  output logic ws_level
);
  logic bclk_d, ws_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d <= 1'b0;
      ws_d   <= 1'b0;
    end else begin
      bclk_d <= bclk_s;
      ws_d   <= ws_s;
    end
  end

  assign bclk_fall = bclk_d & ~bclk_s;
  assign ws_change = ws_d ^ ws_s;
  assign ws_level  = ws_s;
endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter
  import sstx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  localparam int CW = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] left_sample,
  input  logic [SAMPLE_W-1:0] right_sample,
  input  logic                bclk_fall,
  input  logic                ws_change,
  input  logic                ws_level,
  output logic                sd_q,
  output logic [CW-1:0]       bit_cnt
);
  localparam logic [CW-1:0] CNT_FULL = CW'(SAMPLE_W);

  logic [SAMPLE_W-1:0] sreg_q, base_sreg;
  logic [CW-1:0]       cnt_q, base_cnt, next_cnt;

  // A word-select change takes effect before a falling edge detected in the same cycle
  always_comb begin
    if (ws_change) begin
      base_sreg = (chan_of(ws_level) == CH_RIGHT) ? right_sample : left_sample;
      base_cnt  = '0;
    end else begin
      base_sreg = sreg_q;
      base_cnt  = cnt_q;
    end
    next_cnt = (base_cnt == CNT_FULL) ? base_cnt : base_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      cnt_q  <= CNT_FULL;
      sd_q   <= 1'b0;
    end else if (bclk_fall) begin
      sd_q   <= (base_cnt < CNT_FULL) ? base_sreg[SAMPLE_W-1] : 1'b0;
      sreg_q <= {base_sreg[SAMPLE_W-2:0], 1'b0};
      cnt_q  <= next_cnt;
    end else begin
      sreg_q <= base_sreg;
      cnt_q  <= base_cnt;
    end
  end

  assign bit_cnt = cnt_q;
endmodule

// File: rtl/sstx_clkdiv.sv
module sstx_clkdiv #(
  parameter int DCLK_LOG2 = 2,
  parameter int WCLK_LOG2 = 8
) (
  input  logic clk,
  input  logic rst,
  output logic dclk_q,
  output logic wclk_q
);
  logic [WCLK_LOG2-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign dclk_q = cnt_q[DCLK_LOG2-1];
  assign wclk_q = cnt_q[WCLK_LOG2-1];
endmodule

// File: rtl/serial_sample_tx.sv
module serial_sample_tx #(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2,
  parameter int DCLK_LOG2   = 2,
  parameter int WCLK_LOG2   = 8,
  localparam int CW = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] left_sample,
  input  logic [SAMPLE_W-1:0] right_sample,
  input  logic                bclk_in,
  input  logic                ws_in,
  input  logic                out_en,
  output logic                sd_o,
  output logic                dclk_o,
  output logic                wclk_o,
  output logic                out_oe
);
  logic          bclk_s, ws_s;
  logic          bclk_fall, ws_change, ws_level;
  logic [CW-1:0] bit_cnt;

  sstx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .async_i({bclk_in, ws_in}),
    .sync_o ({bclk_s, ws_s})
  );

  sstx_edges edges_i (
    .clk      (clk),
    .rst      (rst),
    .bclk_s   (bclk_s),
    .ws_s     (ws_s),
    .bclk_fall(bclk_fall),
    .ws_change(ws_change),
    .ws_level (ws_level)
  );

  sstx_shifter #(.SAMPLE_W(SAMPLE_W)) shift_i (
    .clk         (clk),
    .rst         (rst),
    .left_sample (left_sample),
    .right_sample(right_sample),
    .bclk_fall   (bclk_fall),
    .ws_change   (ws_change),
    .ws_level    (ws_level),
    .sd_q        (sd_o),
    .bit_cnt     (bit_cnt)
  );

  sstx_clkdiv #(.DCLK_LOG2(DCLK_LOG2), .WCLK_LOG2(WCLK_LOG2)) div_i (
    .clk   (clk),
    .rst   (rst),
    .dclk_q(dclk_o),
    .wclk_q(wclk_o)
  );

  always_ff @(posedge clk) begin
    if (rst) out_oe <= 1'b0;
    else     out_oe <= out_en;
  end
endmodule

// File: rtl/sstx_checker.sv
module sstx_checker #(
  parameter int SAMPLE_W = 24,
  localparam int CW = $clog2(SAMPLE_W + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          bclk_fall,
  input logic          ws_change,
  input logic [CW-1:0] bit_cnt,
  input logic          sd_o,
  input logic          dclk_o,
  input logic          wclk_o,
  input logic          out_en,
  input logic          out_oe
);
  assert_hold_without_fall_R2: assert property (@(posedge clk) disable iff (rst)
    !bclk_fall |=> $stable(sd_o));

  assert_pad_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (bclk_fall && !ws_change && (int'(bit_cnt) >= SAMPLE_W)) |=> !sd_o);

  assert_restart_R3: assert property (@(posedge clk) disable iff (rst)
    (ws_change && !bclk_fall) |=> (bit_cnt == '0));

  assert_restart_coincident_R3: assert property (@(posedge clk) disable iff (rst)
    (ws_change && bclk_fall) |=> (bit_cnt == CW'(1)));

  assert_oe_on_R5: assert property (@(posedge clk) disable iff (rst)
    out_en |=> out_oe);

  assert_oe_off_R5: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !out_oe);

  assert_word_on_data_edge_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(wclk_o) |-> $fell(dclk_o));
endmodule

bind serial_sample_tx sstx_checker #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bclk_fall(bclk_fall),
  .ws_change(ws_change),
  .bit_cnt  (bit_cnt),
  .sd_o     (sd_o),
  .dclk_o   (dclk_o),
  .wclk_o   (wclk_o),
  .out_en   (out_en),
  .out_oe   (out_oe)
);

// File: tb/serial_sample_tx_tb_top.sv
`timescale 1ns/1ps
module serial_sample_tx_tb_top;
  localparam int SW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] left_sample = '0, right_sample = '0;
  logic          bclk_in = 1'b1, ws_in = 1'b0, out_en = 1'b0;
  logic          sd_o, dclk_o, wclk_o, out_oe;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;
  logic prev_bit = 1'b0;

  always #2 clk = ~clk;

  serial_sample_tx dut_i (
    .clk(clk), .rst(rst), .left_sample(left_sample), .right_sample(right_sample),
    .bclk_in(bclk_in), .ws_in(ws_in), .out_en(out_en),
    .sd_o(sd_o), .dclk_o(dclk_o), .wclk_o(wclk_o), .out_oe(out_oe)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [SW-1:0] pattern(input int k);
    return SW'((k * 32'h009E3779 + 32'h00A5C3F1 * (k + 1)) ^ (k << 11));
  endfunction

  // One word: ws change, then nbits bit-clock periods of 4 low / 4 high cycles
  task automatic send_word(input int idx, input int nbits, input bit coincident, input bit midupd);
    logic          lvl;
    logic [SW-1:0] sent;
    logic          exp_bit;
    lvl = ~ws_in;
    left_sample  = pattern(2 * idx);
    right_sample = pattern(2 * idx + 1);
    if (idx == 0) right_sample = 24'h800001;
    if (idx == 1) left_sample  = 24'hFFFFFF;
    sent = lvl ? right_sample : left_sample;
    if (!coincident) begin
      ws_in = lvl;
      wait_neg(4);
    end
    for (int i = 0; i < nbits; i++) begin
      if (i == 0 && coincident) ws_in = lvl;
      bclk_in = 1'b0;
      exp_bit = (i < SW) ? sent[SW-1-i] : 1'b0;
      wait_neg(2);
      check("R2", "hold two edges after fall", int'(sd_o), int'(prev_bit));
      wait_neg(1);
      if (i == 0)
        check("R3", "MSB after word select change", int'(sd_o), int'(exp_bit));
      else if (i >= SW)
        check("R4", "padding bit", int'(sd_o), int'(exp_bit));
      else if (midupd && i > 5)
        check("R6", "bit after sample input update", int'(sd_o), int'(exp_bit));
      else
        check("R1", lvl ? "right channel bit" : "left channel bit", int'(sd_o), int'(exp_bit));
      prev_bit = exp_bit;
      if (midupd && i == 5) begin
        left_sample  = ~left_sample;
        right_sample = ~right_sample;
      end
      wait_neg(1);
      bclk_in = 1'b1;
      wait_neg(4);
    end
  endtask

  initial begin
    rst = 1'b1;
    wait_neg(3);
    check("R8", "sd_o in reset", int'(sd_o), 0);
    check("R8", "out_oe in reset", int'(out_oe), 0);
    check("R8", "dclk_o in reset", int'(dclk_o), 0);
    check("R8", "wclk_o in reset", int'(wclk_o), 0);
    rst = 1'b0;
    // R7: divider sweep, m rising edges since release
    for (int m = 1; m <= 512; m++) begin
      wait_neg(1);
      check("R7", "dclk_o", int'(dclk_o), (m >> 1) & 1);
      check("R7", "wclk_o", int'(wclk_o), (m >> 7) & 1);
    end
    // R5: registered pad enable
    out_en = 1'b1;
    check("R5", "out_oe before edge", int'(out_oe), 0);
    wait_neg(1);
    check("R5", "out_oe after enable", int'(out_oe), 1);
    // R8: falling edges before any word-select change send zero
    left_sample  = 24'hFFFFFF;
    right_sample = 24'hFFFFFF;
    for (int i = 0; i < 3; i++) begin
      bclk_in = 1'b0;
      wait_neg(4);
      check("R8", "bit before first word", int'(sd_o), 0);
      bclk_in = 1'b1;
      wait_neg(4);
    end
    // Words of assorted lengths, both channels, coincident edges, mid-word updates
    send_word(0, 24, 1'b0, 1'b0);
    send_word(1, 32, 1'b0, 1'b0);
    send_word(2, 16, 1'b0, 1'b0);
    send_word(3, 25, 1'b1, 1'b0);
    send_word(4, 24, 1'b0, 1'b1);
    send_word(5, 31, 1'b0, 1'b1);
    send_word(6, 28, 1'b1, 1'b0);
    send_word(7, 24, 1'b0, 1'b0);
    send_word(8, 32, 1'b1, 1'b1);
    send_word(9, 20, 1'b0, 1'b0);
    out_en = 1'b0;
    check("R5", "out_oe before edge", int'(out_oe), 1);
    wait_neg(1);
    check("R5", "out_oe after disable", int'(out_oe), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule